// File: doc/BRIEF.md
# Paged GPIO Controller with Edge Interrupts

This block is a byte-wide, register-mapped general-purpose I/O controller for 48 lines. The lines are grouped into six 8-bit ports. Each line has an output latch. When a latch bit is 1 the line is driven. When it is 0 the line is released and acts as an input. Reading a port's data offset returns the pin levels after a two-flop synchronizer.

The lines of the three lowest ports can also capture edge events. Each of these lines has an enable bit, a polarity bit and a sticky event bit. A small page register chooses which of these three per-port banks the three interrupt offsets reach. This keeps the whole device inside a 16-byte window.

An event is acknowledged by clearing its enable bit and then setting it again. A summary of pending ports can be read at one offset. A single level interrupt output is high while any latched event exists.

Top module: `paged_gpio_irq`

## Requirements
- R1: During and after synchronous reset (rst_n low at a clock edge), every output latch, enable, polarity and event bit is 0, irq is 0, bus_rdata is 0, and the page register holds the ID code 0xC0.
- R2: A write to offset k (0 to 5) loads the output latch of port k. pin_drive bit 8k+b equals latch bit b from the edge that takes the write onward.
- R3: A read of offset k (0 to 5) returns pin_in bits 8k+7..8k as seen through two synchronizer flops. A read issued in the cycle after a pin change still returns the old level. The next read returns the new level.
- R4: Offset 7 is the page register. Writing 0x80 selects the enable bank, 0x40 selects the polarity bank and 0xC0 selects the ID bank. Any other written value leaves the page unchanged. Reading offset 7 returns the current page code.
- R5: Offsets 8, 9 and 10 address ports 0, 1 and 2 in the selected bank. In the enable and polarity banks they read and write that port's bits. In the ID bank a read returns the port's latched event bits and a write has no effect.
- R6: A line with polarity 1 latches a rising edge, and a line with polarity 0 latches a falling edge. An event is latched only while the line's enable bit is 1. The event bit sets at the third clock edge after the pin change. Ports 3 to 5 never latch events.
- R7: Writing 0 to an enable bit clears that line's event bit at the same edge. After the bit is set again, a later qualifying edge latches a new event.
- R8: A read of offset 6 returns the pending flags of ports 0, 1 and 2 in bits 0, 1 and 2, with zeros above. Each flag is the OR of that port's event bits. irq is the OR of the three flags.
- R9: bus_rdata is registered. It takes the addressed value at a clock edge where bus_rd is 1 and holds its value otherwise.
- R10: Offsets 11 to 15 read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Byte offset within the 16-byte window |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, loads bus_rdata at the edge |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 48 | Asynchronous pin levels, line n at bit n |
| pin_drive | output | 48 | Drive enables, 1 drives line n |
| irq | output | 1 | Level interrupt request |

## Verification
A wrong enable or polarity bit stays hidden until a pin edge arrives. It then shows as an irq transition that is missing or extra, exactly three edges after the pin change. It also shows in the next read of offset 6 or of the ID bank.

A corrupted page register shows up at the very next access to offsets 8 to 10: that access reads or writes the wrong bank. A stale synchronizer stage shows as a port read that lags or leads by one cycle.

The reference model tracks all of this state every cycle. It compares irq, pin_drive and bus_rdata after each edge, so any divergence is reported within one clock.

// File: rtl/paged_gpio_pkg.sv
// Shared constants for the paged GPIO controller: geometry, bus offsets
// and page codes. Assumes a 4-bit byte address window.
package paged_gpio_pkg;
    localparam int PORT_W      = 8;
    localparam int N_PORTS     = 6;
    localparam int N_IRQ_PORTS = 3;
    localparam int ADDR_W      = 4;

    localparam logic [ADDR_W-1:0] OFS_PEND = 4'd6;
    localparam logic [ADDR_W-1:0] OFS_PAGE = 4'd7;
    localparam int                OFS_BANK = 8;

    localparam logic [7:0] PAGE_EN  = 8'h80;
    localparam logic [7:0] PAGE_POL = 8'h40;
    localparam logic [7:0] PAGE_ID  = 8'hC0;
endpackage

// File: rtl/pgio_sync.sv
// Two-flop synchronizer for a bus of asynchronous pin levels.
// Assumes each bit is treated independently (no multi-bit coherence).
module pgio_sync #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Shift the pin levels through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/pgio_edge_port.sv
// Edge capture for one port: enable, polarity and sticky event bits.
// Assumes lvl is already synchronized. Events need the post-write enable.
module pgio_edge_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic         wr_en_bank,
    input  logic         wr_pol_bank,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] en_q,
    output logic [W-1:0] pol_q,
    output logic [W-1:0] evt_q
);
    logic [W-1:0] prev_q;
    logic [W-1:0] en_d;
    logic [W-1:0] hit;

    // Next enable value, visible to the event latch in the same cycle.
    always_comb begin
        en_d = wr_en_bank ? wdata : en_q;
    end

    // Edge qualified by polarity: 1 selects rising, 0 selects falling.
    always_comb begin
        hit = (lvl & ~prev_q & pol_q) | (~lvl & prev_q & ~pol_q);
    end

    // Register banks, previous level and sticky events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            pol_q  <= '0;
            evt_q  <= '0;
            prev_q <= '0;
        end else begin
            en_q   <= en_d;
            if (wr_pol_bank) pol_q <= wdata;
            evt_q  <= en_d & (evt_q | hit);
            prev_q <= lvl;
        end
    end

    // An event never survives with its enable low.
    p_evt_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_q & ~en_q) == '0);

    // A latched event stays while its enable remains high.
    p_evt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(evt_q) & en_q & ~evt_q) == '0));
endmodule

// File: rtl/paged_gpio_irq.sv
// Paged GPIO controller: six data ports, page-multiplexed interrupt banks
// for the lowest ports, pending summary and one level interrupt.
// Assumes single-cycle bus strobes and a synchronous active-low reset.
module paged_gpio_irq
    import paged_gpio_pkg::*;
#(
    parameter int P_W     = PORT_W,
    parameter int P_N     = N_PORTS,
    parameter int P_NIRQ  = N_IRQ_PORTS,
    parameter int P_ADDRW = ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [P_ADDRW-1:0] bus_addr,
    input  logic [7:0]         bus_wdata,
    input  logic               bus_wr,
    input  logic               bus_rd,
    output logic [7:0]         bus_rdata,
    input  logic [P_N*P_W-1:0] pin_in,
    output logic [P_N*P_W-1:0] pin_drive,
    output logic               irq
);
    localparam int NLINES = P_N * P_W;

    logic [NLINES-1:0]             lvl;
    logic [P_N-1:0][P_W-1:0]       lvl_p;
    logic [P_N-1:0][P_W-1:0]       drv_q;
    logic [7:0]                    page_q;
    logic [P_NIRQ-1:0][P_W-1:0]    en_a;
    logic [P_NIRQ-1:0][P_W-1:0]    pol_a;
    logic [P_NIRQ-1:0][P_W-1:0]    evt_a;
    logic [P_NIRQ-1:0]             pend;
    logic [7:0]                    rd_mux;
    logic                          page_ok;

    pgio_sync #(.W(NLINES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (lvl)
    );

    assign lvl_p     = lvl;
    assign pin_drive = drv_q;

    // Output latches, one byte per port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_q <= '0;
        end else if (bus_wr) begin
            for (int p = 0; p < P_N; p++) begin
                if (bus_addr == P_ADDRW'(p)) drv_q[p] <= bus_wdata[P_W-1:0];
            end
        end
    end

    // Accept only the three legal page codes.
    always_comb begin
        page_ok = (bus_wdata == PAGE_EN) || (bus_wdata == PAGE_POL) ||
                  (bus_wdata == PAGE_ID);
    end

    // Page register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= PAGE_ID;
        end else if (bus_wr && bus_addr == OFS_PAGE && page_ok) begin
            page_q <= bus_wdata;
        end
    end

    // Per-port edge capture for the interrupt-capable ports.
    for (genvar p = 0; p < P_NIRQ; p++) begin : g_cap
        logic sel;
        assign sel = bus_wr && (bus_addr == P_ADDRW'(OFS_BANK + p));
        pgio_edge_port #(.W(P_W)) u_cap (
            .clk         (clk),
            .rst_n       (rst_n),
            .lvl         (lvl_p[p]),
            .wr_en_bank  (sel && page_q == PAGE_EN),
            .wr_pol_bank (sel && page_q == PAGE_POL),
            .wdata       (bus_wdata[P_W-1:0]),
            .en_q        (en_a[p]),
            .pol_q       (pol_a[p]),
            .evt_q       (evt_a[p])
        );
        assign pend[p] = |evt_a[p];
    end

    assign irq = |pend;

    // Read multiplexer over the whole window; unmapped offsets give 0.
    always_comb begin
        rd_mux = '0;
        for (int p = 0; p < P_N; p++) begin
            if (bus_addr == P_ADDRW'(p)) rd_mux = 8'(lvl_p[p]);
        end
        if (bus_addr == OFS_PEND) rd_mux = 8'(pend);
        if (bus_addr == OFS_PAGE) rd_mux = page_q;
        for (int p = 0; p < P_NIRQ; p++) begin
            if (bus_addr == P_ADDRW'(OFS_BANK + p)) begin
                case (page_q)
                    PAGE_EN:  rd_mux = 8'(en_a[p]);
                    PAGE_POL: rd_mux = 8'(pol_a[p]);
                    default:  rd_mux = 8'(evt_a[p]);
                endcase
            end
        end
    end

    // Registered read data, loaded only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    // Page register only ever holds a legal code.
    p_page_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (page_q == PAGE_EN) || (page_q == PAGE_POL) || (page_q == PAGE_ID));

    // Read data holds between read strobes.
    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // Unmapped offsets read as zero.
    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr > P_ADDRW'(OFS_BANK + P_NIRQ - 1)) |=> (bus_rdata == 8'h00));

    // A data write lands on the matching port's drive pins.
    for (genvar p = 0; p < P_N; p++) begin : g_drv_chk
        p_drive_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == P_ADDRW'(p)) |=>
            (pin_drive[p*P_W +: P_W] == $past(bus_wdata[P_W-1:0])));
    end
endmodule

// File: tb/paged_gpio_irq_bench.sv
`timescale 1ns/1ps
module paged_gpio_irq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic [47:0] pin_in = '0;
    logic [47:0] pin_drive;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    bit started = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    paged_gpio_irq u_paged_gpio_irq (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_drive(pin_drive), .irq(irq)
    );

    // Behavioural reference model state.
    logic [7:0]  m_drv [6];
    logic [7:0]  m_en  [3];
    logic [7:0]  m_pol [3];
    logic [7:0]  m_evt [3];
    logic [7:0]  m_page;
    logic [7:0]  m_rd;
    logic [47:0] m_hist [$];

    function automatic logic [47:0] seen(int age);
        return m_hist[age];
    endfunction

    function automatic logic [7:0] m_read(logic [3:0] a);
        logic [7:0] pend;
        logic [47:0] s;
        pend = 0;
        for (int k = 0; k < 3; k++) pend[k] = (m_evt[k] != 0);
        s = seen(1);
        if (a < 6) return s[a*8 +: 8];
        if (a == 6) return pend;
        if (a == 7) return m_page;
        if (a >= 8 && a <= 10) begin
            if (m_page == 8'h80) return m_en[a-8];
            if (m_page == 8'h40) return m_pol[a-8];
            return m_evt[a-8];
        end
        return 8'h00;
    endfunction

    function automatic logic m_irq();
        return (m_evt[0] | m_evt[1] | m_evt[2]) != 0;
    endfunction

    function automatic logic [47:0] m_drive();
        logic [47:0] d;
        for (int k = 0; k < 6; k++) d[k*8 +: 8] = m_drv[k];
        return d;
    endfunction

    // Model update at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 6; k++) m_drv[k] = 0;
            for (int k = 0; k < 3; k++) begin
                m_en[k] = 0; m_pol[k] = 0; m_evt[k] = 0;
            end
            m_page = 8'hC0;
            m_rd = 0;
            m_hist = '{48'h0, 48'h0, 48'h0};
        end else begin
            logic [7:0] en_n [3];
            logic [47:0] now_l, old_l;
            now_l = seen(1);
            old_l = seen(2);
            for (int k = 0; k < 3; k++) begin
                en_n[k] = m_en[k];
                if (bus_wr && bus_addr == 4'(8 + k) && m_page == 8'h80) en_n[k] = bus_wdata;
            end
            if (bus_rd) m_rd = m_read(bus_addr);
            for (int k = 0; k < 3; k++) begin
                for (int b = 0; b < 8; b++) begin
                    bit r, f, h;
                    r = now_l[k*8+b] && !old_l[k*8+b];
                    f = !now_l[k*8+b] && old_l[k*8+b];
                    h = m_pol[k][b] ? r : f;
                    m_evt[k][b] = en_n[k][b] && (m_evt[k][b] || h);
                end
            end
            if (bus_wr) begin
                if (bus_addr < 6) m_drv[bus_addr] = bus_wdata;
                if (bus_addr == 7 && (bus_wdata == 8'h80 || bus_wdata == 8'h40 || bus_wdata == 8'hC0))
                    m_page = bus_wdata;
                if (bus_addr >= 8 && bus_addr <= 10 && m_page == 8'h40) m_pol[bus_addr-8] = bus_wdata;
            end
            for (int k = 0; k < 3; k++) m_en[k] = en_n[k];
            void'(m_hist.pop_back());
            m_hist.push_front(pin_in);
        end
        started = 1;
    end

    task automatic chk(string tag, string what, logic [47:0] act, logic [47:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    // Compare the design against the model after every edge.
    always @(negedge clk) begin
        if (started && !done) begin
            chk("R8", "irq vs model", 48'(irq), 48'(m_irq()));
            chk("R2", "pin_drive vs model", pin_drive, m_drive());
            chk("R9", "rdata vs model", 48'(bus_rdata), 48'(m_rd));
        end
    end

    task automatic wr(logic [3:0] a, logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(logic [3:0] a, logic [7:0] exp, string tag);
        @(negedge clk); bus_addr = a; bus_rd = 1;
        @(negedge clk); bus_rd = 0;
        chk(tag, $sformatf("read offset %0d", a), 48'(bus_rdata), 48'(exp));
    endtask

    task automatic set_pins(logic [47:0] v);
        @(negedge clk); pin_in = v;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk("R1", "irq in reset", 48'(irq), 48'h0);
        chk("R1", "drive in reset", pin_drive, 48'h0);
        chk("R1", "rdata in reset", 48'(bus_rdata), 48'h0);
        rst_n = 1;
        rd(4'd7, 8'hC0, "R1");
        rd(4'd8, 8'h00, "R1");

        wr(4'd0, 8'hA5);
        wr(4'd5, 8'h3C);
        chk("R2", "port0 drive", 48'(pin_drive[7:0]), 48'hA5);
        chk("R2", "port5 drive", 48'(pin_drive[47:40]), 48'h3C);

        set_pins(48'h1234_5678_9ABC);
        rd(4'd0, 8'h00, "R3");
        rd(4'd0, 8'hBC, "R3");
        rd(4'd5, 8'h12, "R3");

        wr(4'd7, 8'h55);
        rd(4'd7, 8'hC0, "R4");
        wr(4'd7, 8'h80);
        rd(4'd7, 8'h80, "R4");
        wr(4'd8, 8'hFF);
        wr(4'd9, 8'h0F);
        rd(4'd8, 8'hFF, "R5");
        wr(4'd7, 8'h40);
        wr(4'd8, 8'h01);
        rd(4'd8, 8'h01, "R5");
        rd(4'd9, 8'h00, "R5");
        wr(4'd7, 8'hC0);
        wr(4'd8, 8'hAA);
        rd(4'd8, 8'h00, "R5");

        // Rising edge on port 0 line 0, polarity 1.
        set_pins(48'h1234_5678_9ABD);
        @(negedge clk); chk("R6", "irq one edge after pin change", 48'(irq), 48'h0);
        @(negedge clk); chk("R6", "irq two edges after pin change", 48'(irq), 48'h0);
        @(negedge clk); chk("R6", "irq three edges after pin change", 48'(irq), 48'h1);
        rd(4'd6, 8'h01, "R8");
        rd(4'd8, 8'h01, "R5");

        // Falling on line 2 (pol 0) latches; rising on line 6 (pol 0) does not.
        set_pins(48'h1234_5678_9AB9); idle(4);
        set_pins(48'h1234_5678_9AF9); idle(4);
        rd(4'd8, 8'h05, "R6");

        // Port 1: line 7 disabled, line 1 enabled falling.
        set_pins(48'h1234_5678_18F9); idle(4);
        rd(4'd6, 8'h03, "R8");
        rd(4'd9, 8'h02, "R6");

        // Ports 2 to 5 changes latch nothing.
        set_pins(48'hEDCB_A987_18F9); idle(4);
        rd(4'd6, 8'h03, "R6");

        // Acknowledge port 0 lines 0 and 2, then re-arm.
        wr(4'd7, 8'h80);
        wr(4'd8, 8'hFA);
        wr(4'd8, 8'hFF);
        wr(4'd7, 8'hC0);
        rd(4'd8, 8'h00, "R7");
        rd(4'd6, 8'h02, "R7");
        wr(4'd7, 8'h80);
        wr(4'd9, 8'h0D);
        wr(4'd9, 8'h0F);
        rd(4'd6, 8'h00, "R7");
        chk("R8", "irq after full acknowledge", 48'(irq), 48'h0);

        // Re-armed line latches a new falling edge.
        set_pins(48'hEDCB_A987_1AF9); idle(4);
        set_pins(48'hEDCB_A987_18F9); idle(4);
        rd(4'd6, 8'h02, "R7");
        chk("R8", "irq after re-armed event", 48'(irq), 48'h1);

        // Unmapped offsets.
        wr(4'd11, 8'hFF);
        wr(4'd12, 8'h77);
        rd(4'd11, 8'h00, "R10");
        rd(4'd15, 8'h00, "R10");
        chk("R10", "drive untouched by unmapped write", pin_drive, 48'h3C00_0000_00A5);
        rd(4'd7, 8'h80, "R10");

        // Read data holds without a strobe.
        bus_addr = 4'd6;
        idle(3);
        chk("R9", "rdata held", 48'(bus_rdata), 48'h80);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule